// File: doc/BRIEF.md
# Protected-Mode Segment Descriptor Cache with Access Checking

This block stands in for a single segment register of a protected-mode address unit. Software writes a 16-bit selector. The block decodes the selector into a table choice, a descriptor index and a requested privilege level. If the selector differs from the one already cached, the block reads the 8-byte descriptor through a 32-bit memory port. It keeps the base, the limit, the granularity flag and the rights byte in a hidden cache. If the descriptor's accessed flag was clear, the block writes that flag back to memory.

Each later access presents an offset, a kind (read, write or execute) and the current privilege level. The block checks the access against the cached descriptor and never goes back to the table. One cycle later it returns either the linear address, which is the cached base plus the offset, or a fault vector.

Top module: `seg_guard`

## Requirements
- R1: A selector is split as bits 15:3 = descriptor index, bit 2 = table choice (0 picks `gtab_base`, 1 picks `ltab_base`), bits 1:0 = requested privilege. The descriptor's low word is read at table base + index*8 and its high word at that address + 4, in two consecutive read transactions.
- R2: A selector write whose value equals the cached selector of a completed load starts no memory transaction. A selector write while `busy` is high is ignored.
- R3: Descriptor layout: low word bits 15:0 = limit 15:0, low word bits 31:16 = base 15:0. High word bits 7:0 = base 23:16, bits 15:8 = rights byte, bits 19:16 = limit 19:16, bit 23 = granularity, bits 31:24 = base 31:24. A passing access returns `res_lin` = base + offset modulo 2^32.
- R4: With granularity 0 the effective limit is the 20-bit limit in bytes. With granularity 1 it is (limit<<12)|0xFFF. For a segment that is not expand-down, an offset above the effective limit faults with vector 13.
- R5: For a data segment with the direction bit set (rights bit 2), an offset at or below the effective limit faults with vector 13, and an offset above it passes.
- R6: If the present bit (rights bit 7) is 0, every access faults with vector 11, and this fault takes precedence over all other checks. After reset, the cache holds a not-present descriptor.
- R7: The access level is the larger of `acc_cpl` and the cached requested privilege. If it is numerically greater than the descriptor privilege (rights bits 6:5), the access faults with vector 13.
- R8: Rights bit 3 set marks code, and bit 1 grants read for code or write for data. The following fault with vector 13: a write to code, a read of code without read permission, an execute of data, a write to data without write permission, any access with rights bit 4 clear (system descriptor), and kind code 3. Kind codes: 0 = read, 1 = write, 2 = execute.
- R9: If rights bit 0 (accessed) of the fetched high word is 0, a third transaction writes the high word back with bit 8 set, at the high-word address. If the bit is already 1, no write occurs.
- R10: `res_valid` pulses one cycle after an `acc_valid` that arrives while `busy` is low. An access presented while `busy` is high produces no result. On a pass, `res_fault` = 0 and `res_vec` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_wr | input | 1 | Selector write strobe |
| sel_in | input | 16 | Selector value |
| gtab_base | input | 32 | Global table base address |
| ltab_base | input | 32 | Local table base address |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Transaction complete |
| busy | output | 1 | Descriptor load in progress |
| acc_valid | input | 1 | Access request |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute |
| acc_off | input | 32 | Access offset |
| acc_cpl | input | 2 | Current privilege level |
| res_valid | output | 1 | Result valid |
| res_fault | output | 1 | Access faulted |
| res_vec | output | 8 | Fault vector (11, 13) or 0 |
| res_lin | output | 32 | Linear address |

## Verification
Assertions watch, on every cycle, that the high-word read follows the low-word read at the address 4 higher, that a pending request holds its address, that a repeated selector or an already-accessed descriptor causes no further traffic, that an access during a load gets no result, and that a not-present descriptor always yields vector 11.

Only the directed scenarios can show the rest. They place descriptors in a modelled memory and check the arithmetic: limit scaling at both granularities, the expand-down boundary, the privilege and type matrix, base-plus-offset wraparound, and the exact addresses and write-back contents of each fetch.

// File: rtl/seg_guard.sv
module seg_guard #(
  parameter logic [7:0] NP_VEC = 8'd11,
  parameter logic [7:0] GP_VEC = 8'd13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_wr,
  input  logic [15:0] sel_in,
  input  logic [31:0] gtab_base,
  input  logic [31:0] ltab_base,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        busy,
  input  logic        acc_valid,
  input  logic [1:0]  acc_kind,
  input  logic [31:0] acc_off,
  input  logic [1:0]  acc_cpl,
  output logic        res_valid,
  output logic        res_fault,
  output logic [7:0]  res_vec,
  output logic [31:0] res_lin
);
  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_WB} st_t;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_EX = 2'd2;

  st_t         st;
  logic [15:0] c_sel;
  logic        c_ok, c_g;
  logic [31:0] c_base, f_addr, t_lo, t_hi;
  logic [19:0] c_lim;
  logic [7:1]  c_acc;

  assign busy      = st != S_IDLE;
  assign mem_req   = busy;
  assign mem_we    = st == S_WB;
  assign mem_addr  = (st == S_LO) ? f_addr : f_addr + 32'd4;
  assign mem_wdata = t_hi | 32'h0000_0100;

  wire load_go = sel_wr && !busy && !(c_ok && sel_in == c_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; c_sel <= '0; c_ok <= 1'b0; c_g <= 1'b0;
      c_base <= '0; c_lim <= '0; c_acc <= '0;
      f_addr <= '0; t_lo <= '0; t_hi <= '0;
    end else begin
      case (st)
        S_IDLE: if (load_go) begin
          c_sel  <= sel_in;
          c_ok   <= 1'b0;
          f_addr <= (sel_in[2] ? ltab_base : gtab_base) + {16'b0, sel_in[15:3], 3'b000};
          st     <= S_LO;
        end
        S_LO: if (mem_ack) begin
          t_lo <= mem_rdata;
          st   <= S_HI;
        end
        S_HI: if (mem_ack) begin
          t_hi   <= mem_rdata;
          c_base <= {mem_rdata[31:24], mem_rdata[7:0], t_lo[31:16]};
          c_lim  <= {mem_rdata[19:16], t_lo[15:0]};
          c_g    <= mem_rdata[23];
          c_acc  <= mem_rdata[15:9];
          c_ok   <= 1'b1;
          st     <= mem_rdata[8] ? S_IDLE : S_WB;
        end
        default: if (mem_ack) st <= S_IDLE;
      endcase
    end
  end

  wire [31:0] lim_eff = c_g ? {c_lim, 12'hFFF} : {12'h000, c_lim};
  wire        is_code = c_acc[3];
  wire        perm    = c_acc[1];
  wire [1:0]  lvl     = (acc_cpl > c_sel[1:0]) ? acc_cpl : c_sel[1:0];
  wire        priv_bad = lvl > c_acc[6:5];
  wire        type_bad = !c_acc[4] || acc_kind == 2'd3 ||
                         (is_code ? (acc_kind == K_WR || (acc_kind == K_RD && !perm))
                                  : (acc_kind == K_EX || (acc_kind == K_WR && !perm)));
  wire        lim_bad  = (!is_code && c_acc[2]) ? (acc_off <= lim_eff) : (acc_off > lim_eff);
  wire [7:0]  vec      = !c_acc[7] ? NP_VEC : (priv_bad || type_bad || lim_bad) ? GP_VEC : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0; res_fault <= 1'b0; res_vec <= '0; res_lin <= '0;
    end else begin
      res_valid <= acc_valid && !busy;
      if (acc_valid && !busy) begin
        res_vec   <= vec;
        res_fault <= vec != 8'd0;
        res_lin   <= c_base + acc_off;
      end
    end
  end

  a_r1_hi_follows_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LO && mem_ack) |=> (mem_req && !mem_we && mem_addr == $past(mem_addr) + 32'd4));
  a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  a_r2_same_sel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !busy && c_ok && sel_in == c_sel) |=> !mem_req);
  a_r9_no_redundant_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HI && mem_ack && mem_rdata[8]) |=> !mem_req);
  a_r10_no_result_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && busy) |=> !res_valid);
  a_r6_not_present: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !busy && !c_acc[7]) |=> (res_valid && res_fault && res_vec == NP_VEC));
endmodule

// File: tb/seg_guard_tb_top.sv
module seg_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_wr = 1'b0; logic [15:0] sel_in = '0;
  logic [31:0] gtab_base = 32'h0, ltab_base = 32'h80;
  logic mem_req, mem_we, mem_ack; logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic busy, acc_valid = 1'b0; logic [1:0] acc_kind = '0, acc_cpl = '0; logic [31:0] acc_off = '0;
  logic res_valid, res_fault; logic [7:0] res_vec; logic [31:0] res_lin;

  int checks = 0, fails = 0, rd_cnt = 0, wr_cnt = 0;
  logic [31:0] ra_prev = '0, ra_last = '0, wa_last = '0;
  logic [31:0] mem [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_guard dut_i (.clk, .rst_n, .sel_wr, .sel_in, .gtab_base, .ltab_base,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack, .busy,
    .acc_valid, .acc_kind, .acc_off, .acc_cpl, .res_valid, .res_fault, .res_vec, .res_lin);

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) if (mem_req) begin
    if (mem_we) begin mem[mem_addr[7:2]] = mem_wdata; wr_cnt++; wa_last = mem_addr; end
    else begin rd_cnt++; ra_prev = ra_last; ra_last = mem_addr; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  task automatic put(input int word, input logic [31:0] base, input logic [19:0] lim,
                     input logic [7:0] rights, input logic g);
    mem[word]     = {base[15:0], lim[15:0]};
    mem[word + 1] = {base[31:24], g, 1'b1, 2'b00, lim[19:16], rights, base[23:16]};
  endtask

  task automatic load(input logic [15:0] s);
    @(negedge clk); rd_cnt = 0; wr_cnt = 0;
    sel_wr = 1'b1; sel_in = s;
    @(negedge clk); sel_wr = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic acc(input string tag, input logic [1:0] k, input logic [31:0] off, input logic [1:0] cpl,
                     input logic [7:0] exp_vec, input logic [31:0] exp_lin);
    @(negedge clk); acc_valid = 1'b1; acc_kind = k; acc_off = off; acc_cpl = cpl;
    @(negedge clk); acc_valid = 1'b0;
    chk({tag, " R10 valid"}, {31'b0, res_valid}, 32'd1);
    chk({tag, " vec"}, {24'b0, res_vec}, {24'b0, exp_vec});
    chk({tag, " fault"}, {31'b0, res_fault}, {31'b0, exp_vec != 0});
    if (exp_vec == 0) chk({tag, " R3 lin"}, res_lin, exp_lin);
  endtask

  task automatic t_reset;
    chk("R10 reset res_valid", {31'b0, res_valid}, 32'd0);
    chk("R10 reset busy", {31'b0, busy}, 32'd0);
    acc("R6 reset cache", RD, 32'h0, 2'd0, 8'd11, 32'h0);
  endtask

  task automatic t_gdt_basic;
    put(2, 32'h0000_1000, 20'h000FF, 8'h92, 1'b0);
    load(16'h0008);
    chk("R1 reads", rd_cnt, 32'd2);
    chk("R1 lo addr", ra_prev, 32'h08);
    chk("R1 hi addr", ra_last, 32'h0C);
    chk("R9 wb count", wr_cnt, 32'd1);
    chk("R9 wb addr", wa_last, 32'h0C);
    chk("R9 wb rights", {24'b0, mem[3][15:8]}, 32'h93);
    acc("R4 at limit", RD, 32'hFF, 2'd0, 8'd0, 32'h0000_10FF);
    acc("R4 past limit", RD, 32'h100, 2'd0, 8'd13, 32'h0);
    acc("R8 data write", WR, 32'h10, 2'd0, 8'd0, 32'h0000_1010);
  endtask

  task automatic t_same_sel;
    load(16'h0008);
    repeat (3) @(negedge clk);
    chk("R2 same selector reads", rd_cnt, 32'd0);
    chk("R2 same selector writes", wr_cnt, 32'd0);
  endtask

  task automatic t_ldt_wrap;
    put(36, 32'hFFFF_F000, 20'hFFFFF, 8'h93, 1'b1);
    load(16'h0014);
    chk("R1 ldt lo addr", ra_prev, 32'h90);
    chk("R1 ldt hi addr", ra_last, 32'h94);
    chk("R9 no wb when set", wr_cnt, 32'd0);
    acc("R3 wrap", RD, 32'h2000, 2'd0, 8'd0, 32'h0000_1000);
    acc("R4 top offset", WR, 32'hFFFF_FFFF, 2'd0, 8'd0, 32'hFFFF_EFFF);
  endtask

  task automatic t_gran;
    put(4, 32'h0, 20'h00001, 8'h93, 1'b1);
    load(16'h0010);
    acc("R4 g1 at limit", RD, 32'h1FFF, 2'd0, 8'd0, 32'h1FFF);
    acc("R4 g1 past limit", RD, 32'h2000, 2'd0, 8'd13, 32'h0);
  endtask

  task automatic t_expand_down;
    put(6, 32'h0000_4000, 20'h00FFF, 8'h97, 1'b0);
    load(16'h0018);
    acc("R5 at limit", RD, 32'hFFF, 2'd0, 8'd13, 32'h0);
    acc("R5 above limit", WR, 32'h1000, 2'd0, 8'd0, 32'h5000);
  endtask

  task automatic t_not_present;
    put(8, 32'h0000_2000, 20'h0FFFF, 8'h13, 1'b0);
    load(16'h0020);
    acc("R6 not present", WR, 32'h10, 2'd3, 8'd11, 32'h0);
  endtask

  task automatic t_priv;
    put(10, 32'h0000_2000, 20'h0FFFF, 8'h93, 1'b0);
    put(12, 32'h0000_2000, 20'h0FFFF, 8'hF3, 1'b0);
    load(16'h002B);
    acc("R7 rpl3 dpl0", RD, 32'h10, 2'd0, 8'd13, 32'h0);
    load(16'h0028);
    acc("R7 cpl0 dpl0", RD, 32'h10, 2'd0, 8'd0, 32'h2010);
    acc("R7 cpl3 dpl0", RD, 32'h10, 2'd3, 8'd13, 32'h0);
    load(16'h0030);
    acc("R7 cpl3 dpl3", RD, 32'h10, 2'd3, 8'd0, 32'h2010);
  endtask

  task automatic t_types;
    put(14, 32'h0000_2000, 20'h0FFFF, 8'h9B, 1'b0);
    put(16, 32'h0000_2000, 20'h0FFFF, 8'h99, 1'b0);
    put(18, 32'h0000_2000, 20'h0FFFF, 8'h91, 1'b0);
    load(16'h0038);
    acc("R8 code exec", EX, 32'h20, 2'd0, 8'd0, 32'h2020);
    acc("R8 code read", RD, 32'h20, 2'd0, 8'd0, 32'h2020);
    acc("R8 code write", WR, 32'h20, 2'd0, 8'd13, 32'h0);
    load(16'h0040);
    acc("R8 exec-only read", RD, 32'h20, 2'd0, 8'd13, 32'h0);
    acc("R8 exec-only exec", EX, 32'h20, 2'd0, 8'd0, 32'h2020);
    load(16'h0048);
    acc("R8 ro data write", WR, 32'h20, 2'd0, 8'd13, 32'h0);
    acc("R8 data exec", EX, 32'h20, 2'd0, 8'd13, 32'h0);
    acc("R8 ro data read", RD, 32'h20, 2'd0, 8'd0, 32'h2020);
  endtask

  task automatic t_busy;
    put(20, 32'h0000_3000, 20'h0FFFF, 8'h92, 1'b0);
    @(negedge clk); sel_wr = 1'b1; sel_in = 16'h0050;
    @(negedge clk); sel_wr = 1'b0;
    chk("R10 busy during load", {31'b0, busy}, 32'd1);
    acc_valid = 1'b1; acc_kind = RD; acc_off = 32'h4;
    @(negedge clk); acc_valid = 1'b0;
    chk("R10 no result while busy", {31'b0, res_valid}, 32'd0);
    while (busy) @(negedge clk);
    acc("R10 after load", RD, 32'h4, 2'd0, 8'd0, 32'h3004);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_gdt_basic; t_same_sel; t_ldt_wrap; t_gran;
    t_expand_down; t_not_present; t_priv; t_types; t_busy;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule